// File: doc/BRIEF.md
# Serial Peripheral Master with Slave Hold-Off

This block is a synchronous serial peripheral master that runs entirely from the system clock. A word handed over on a valid/ready port is shifted out most significant bit first on the data-out line. At the same time, a word of the same length is gathered from the data-in line. The serial clock comes from a programmable divider. The block supports both idle levels of the serial clock and both choices of sampling edge, which gives four clocking modes.

A small sequencer drives the frame. It asserts the active-low select line, then optionally waits for the slave to grant the transfer through an active-low enable input, then shifts the word, then holds the select line for a tail period before releasing it. The tail is longer in the modes that sample on the leading edge, and a 5-bit field adds further system clocks to it. When the hold option is on and another word is already offered at the end of the tail, the select line stays low and the next word follows in the same frame. The received word is delivered with a one-cycle pulse at the moment the select line is released or held.

Top module: `spi_hs_master`

## Requirements
- R1: After reset, cs_n is 1, busy is 0, rx_valid is 0 and tx_ready is 1. While cs_n is 1 the sequencer is never shifting.
- R2: A serial clock edge occurs every cfg_div+1 system clocks during a word, and each word has exactly 2*cfg_len edges. The last edge returns sclk to its idle level, which equals cfg_cpol, and sclk does not move while cs_n is low outside the shift phase.
- R3: Data-out carries the low cfg_len bits of tx_data MSB first (cfg_len in 2..16). With cfg_cpha=0 it changes on trailing edges and is captured by the slave on leading edges. With cfg_cpha=1 it changes on leading edges and is captured by the slave on trailing edges.
- R4: The master samples miso on the edge opposite the launch edge. rx_data returns the cfg_len sampled bits, the first one sampled in the most significant of those bits, and all bits above cfg_len are zero.
- R5: With cfg_cpha=0, cs_n rises cfg_div+2+cfg_xdly system clocks after the final sclk edge (half a bit, plus one clock, plus the extra delay).
- R6: With cfg_cpha=1, cs_n rises 1+cfg_xdly system clocks after the final sclk edge.
- R7: With cfg_hold=1, a word that is valid at the end of the tail is accepted without cs_n rising, and it is shifted in the same frame. With cfg_hold=1 and no word offered, cs_n rises normally.
- R8: With cfg_five_pin=1, no sclk edge is produced until the two-flop synchronized ena_n reads 0. This check is made before every word, including held ones.
- R9: With cfg_five_pin=0, ena_n has no effect and a word completes while ena_n is 1.
- R10: rx_valid is a one-cycle pulse raised together with the release of cs_n (or with the hold point). busy is 1 from the accept until that point and is 0 in the pulse cycle after a release.
- R11: tx_ready is 1 only when idle or at the end of a tail with cfg_hold=1. A word is accepted when tx_valid and tx_ready are both 1, and cs_n is 0 and busy is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_div | input | DIV_W | Half bit period minus one, in system clocks |
| cfg_len | input | LEN_W | Word length, 2 to MAX_LEN |
| cfg_xdly | input | XDLY_W | Extra system clocks before select release |
| cfg_hold | input | 1 | Keep select low when a next word is waiting |
| cfg_five_pin | input | 1 | Honour the slave enable input |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word can be accepted |
| tx_data | input | MAX_LEN | Transmit word, right aligned |
| rx_valid | output | 1 | One-cycle pulse with the received word |
| rx_data | output | MAX_LEN | Received word, right aligned |
| busy | output | 1 | A frame is in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low select |
| ena_n | input | 1 | Active-low slave enable (asynchronous) |

## Verification
The bench builds the block with its default parameters: an 8-bit divider, a maximum word of 16 bits and a 5-bit extra delay. These values let it reach both ends of the word length (2 and 16), a divider of 0 where every system clock is an edge, and the largest extra tail of 31 clocks. A behavioural slave in the bench follows the serial clock and checks the edge count, the half-period spacing and the release delay in each of the four modes. It also covers a held back-to-back pair and a stall of more than 40 clocks under the enable input.

// File: rtl/spi_hs_pkg.sv
`timescale 1ns/1ps
package spi_hs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TAIL  = 2'd3
  } seq_state_e;

  // System clocks from the final serial edge to select release.
  function automatic int tail_cycles(input logic cpha, input int div, input int xdly);
    int half_bit;
    half_bit = cpha ? 0 : div + 1;
    return half_bit + 1 + xdly;
  endfunction

endpackage

// File: rtl/spi_hs_sync.sv
`timescale 1ns/1ps
module spi_hs_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/spi_hs_clkgen.sv
`timescale 1ns/1ps
module spi_hs_clkgen #(
  parameter int DIV_W = 8,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cpol,
  input  logic [DIV_W-1:0] div,
  input  logic [CNT_W-1:0] nedges,
  output logic             sclk,
  output logic             edge_tick,
  output logic             edge_lead,
  output logic             edge_first,
  output logic             edge_last
);
  logic [DIV_W-1:0] hcnt;
  logic [CNT_W-1:0] ecnt;

  assign edge_tick  = run && (hcnt == div);
  assign edge_lead  = ~ecnt[0];
  assign edge_first = (ecnt == '0);
  assign edge_last  = (ecnt == nedges - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      ecnt <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      hcnt <= '0;
      ecnt <= '0;
      sclk <= cpol;
    end else if (edge_tick) begin
      hcnt <= '0;
      ecnt <= ecnt + CNT_W'(1);
      sclk <= ~sclk;
    end else begin
      hcnt <= hcnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/spi_hs_shifter.sv
`timescale 1ns/1ps
module spi_hs_shifter #(
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [MAX_LEN-1:0] load_data,
  input  logic [LEN_W-1:0]   len,
  input  logic               launch,
  input  logic               sample,
  input  logic               miso,
  output logic               mosi,
  output logic [MAX_LEN-1:0] rx_word
);
  logic [MAX_LEN-1:0] txsh;
  logic [MAX_LEN-1:0] rxsh;

  function automatic logic [MAX_LEN-1:0] align_msb(input logic [MAX_LEN-1:0] d,
                                                   input logic [LEN_W-1:0] n);
    return d << (MAX_LEN - int'(n));
  endfunction

  assign mosi    = txsh[MAX_LEN-1];
  assign rx_word = rxsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txsh <= '0;
      rxsh <= '0;
    end else if (load) begin
      txsh <= align_msb(load_data, len);
      rxsh <= '0;
    end else begin
      if (launch) txsh <= {txsh[MAX_LEN-2:0], 1'b0};
      if (sample) rxsh <= {rxsh[MAX_LEN-2:0], miso};
    end
  end
endmodule

// File: rtl/spi_hs_seq.sv
`timescale 1ns/1ps
module spi_hs_seq
  import spi_hs_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int XDLY_W  = 5,
  parameter int MAX_LEN = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_valid,
  input  logic               cfg_cpha,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic [XDLY_W-1:0]  cfg_xdly,
  input  logic               cfg_hold,
  input  logic               cfg_five_pin,
  input  logic               ena_ok,
  input  logic               edge_tick,
  input  logic               edge_last,
  input  logic [MAX_LEN-1:0] rx_word,
  output logic               tx_ready,
  output logic               load,
  output logic               run,
  output logic               cs_n,
  output logic               busy,
  output logic               rx_valid,
  output logic [MAX_LEN-1:0] rx_data,
  output logic               en_stall
);
  localparam int TW = DIV_W + XDLY_W + 1;

  seq_state_e    st;
  logic [TW-1:0] tcnt;
  logic          tail_done;
  logic          accept;

  assign tail_done = (st == ST_TAIL) && (tcnt == '0);
  assign tx_ready  = (st == ST_IDLE) || (tail_done && cfg_hold);
  assign accept    = tx_valid && tx_ready;
  assign load      = accept;
  assign run       = (st == ST_SHIFT);
  assign busy      = (st != ST_IDLE);
  assign en_stall  = (st == ST_WAIT) && cfg_five_pin && !ena_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      tcnt     <= '0;
      cs_n     <= 1'b1;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            cs_n <= 1'b0;
            st   <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (!en_stall) st <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (edge_tick && edge_last) begin
            st   <= ST_TAIL;
            tcnt <= TW'(tail_cycles(cfg_cpha, int'(cfg_div), int'(cfg_xdly)) - 1);
          end
        end
        ST_TAIL: begin
          if (tcnt != '0) begin
            tcnt <= tcnt - TW'(1);
          end else begin
            rx_valid <= 1'b1;
            rx_data  <= rx_word;
            if (accept) begin
              st <= ST_WAIT;
            end else begin
              cs_n <= 1'b1;
              st   <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_hs_master.sv
`timescale 1ns/1ps
module spi_hs_master #(
  parameter int DIV_W   = 8,
  parameter int MAX_LEN = 16,
  parameter int XDLY_W  = 5,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_cpol,
  input  logic               cfg_cpha,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic [XDLY_W-1:0]  cfg_xdly,
  input  logic               cfg_hold,
  input  logic               cfg_five_pin,
  input  logic               tx_valid,
  output logic               tx_ready,
  input  logic [MAX_LEN-1:0] tx_data,
  output logic               rx_valid,
  output logic [MAX_LEN-1:0] rx_data,
  output logic               busy,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso,
  output logic               cs_n,
  input  logic               ena_n
);
  localparam int CNT_W = LEN_W + 1;

  logic               ena_s;
  logic               ena_ok;
  logic               shifting;
  logic               load;
  logic               en_stall;
  logic               edge_tick;
  logic               edge_lead;
  logic               edge_first;
  logic               edge_last;
  logic               launch;
  logic               sample;
  logic [MAX_LEN-1:0] rx_word;
  logic [CNT_W-1:0]   nedges;

  assign ena_ok = ~ena_s;
  assign nedges = {cfg_len, 1'b0};
  assign launch = edge_tick && (cfg_cpha ? (edge_lead && !edge_first)
                                         : (!edge_lead && !edge_last));
  assign sample = edge_tick && (cfg_cpha ? !edge_lead : edge_lead);

  spi_hs_sync #(.RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ena_n), .q(ena_s)
  );

  spi_hs_clkgen #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(shifting), .cpol(cfg_cpol),
    .div(cfg_div), .nedges(nedges), .sclk(sclk),
    .edge_tick(edge_tick), .edge_lead(edge_lead),
    .edge_first(edge_first), .edge_last(edge_last)
  );

  spi_hs_shifter #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(tx_data),
    .len(cfg_len), .launch(launch), .sample(sample), .miso(miso),
    .mosi(mosi), .rx_word(rx_word)
  );

  spi_hs_seq #(.DIV_W(DIV_W), .XDLY_W(XDLY_W), .MAX_LEN(MAX_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .cfg_cpha(cfg_cpha),
    .cfg_div(cfg_div), .cfg_xdly(cfg_xdly), .cfg_hold(cfg_hold),
    .cfg_five_pin(cfg_five_pin), .ena_ok(ena_ok), .edge_tick(edge_tick),
    .edge_last(edge_last), .rx_word(rx_word), .tx_ready(tx_ready),
    .load(load), .run(shifting), .cs_n(cs_n), .busy(busy),
    .rx_valid(rx_valid), .rx_data(rx_data), .en_stall(en_stall)
  );
endmodule

// File: rtl/spi_hs_chk.sv
`timescale 1ns/1ps
module spi_hs_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic busy,
  input logic tx_valid,
  input logic tx_ready,
  input logic rx_valid,
  input logic cfg_hold,
  input logic shifting,
  input logic en_stall
);
  a_r1_no_shift_when_released: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !shifting);

  a_r2_sclk_quiet_outside_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !shifting) |=> $stable(sclk));

  a_r7_held_select_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cs_n) |-> cfg_hold);

  a_r8_stall_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
    en_stall |=> $stable(sclk));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r10_release_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> rx_valid);

  a_r11_accept_starts_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (!cs_n && busy));
endmodule

bind spi_hs_master spi_hs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .busy(busy),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .cfg_hold(cfg_hold), .shifting(shifting), .en_stall(en_stall)
);

// File: tb/spi_hs_master_tb.sv
`timescale 1ns/1ps
module spi_hs_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_hold = 1'b0, cfg_five_pin = 1'b0;
  logic [7:0]  cfg_div = 8'd1;
  logic [4:0]  cfg_len = 5'd8;
  logic [4:0]  cfg_xdly = 5'd0;
  logic        tx_valid = 1'b0;
  logic [15:0] tx_data = 16'h0;
  logic        tx_ready, rx_valid, busy, sclk, mosi, cs_n;
  logic [15:0] rx_data;
  logic        miso = 1'b0;
  logic        ena_n = 1'b1;

  int errors = 0;
  int checks = 0;

  // 50 MHz
  always #10 clk = ~clk;

  spi_hs_master u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_div(cfg_div), .cfg_len(cfg_len), .cfg_xdly(cfg_xdly),
    .cfg_hold(cfg_hold), .cfg_five_pin(cfg_five_pin), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_data(rx_data), .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso),
    .cs_n(cs_n), .ena_n(ena_n)
  );

  // ---------------- behavioural slave and monitor ----------------
  int          cyc = 0;
  logic        cs_prev = 1'b1, sclk_prev = 1'b0;
  logic [15:0] slv_a = 16'h0, slv_b = 16'h0, s_tx = 16'h0, s_rx = 16'h0;
  int          s_ptr = 0, s_edges = 0, hp_err = 0;
  int          last_edge_cyc = 0, cs_rise_cyc = 0, cs_rises = 0;
  logic [15:0] snap_rx = 16'h0;
  int          snap_edges = 0, snap_last = 0;

  task slave_init(input logic [15:0] w);
    s_tx = w; s_rx = 16'h0; s_edges = 0;
    s_ptr = cfg_cpha ? int'(cfg_len) - 1 : int'(cfg_len) - 2;
    if (!cfg_cpha) miso = w[int'(cfg_len) - 1];
  endtask

  always @(negedge clk) begin
    logic lead;
    cyc = cyc + 1;
    if (cs_prev && !cs_n) begin
      slave_init(slv_a);
    end else if (!cs_n && sclk !== sclk_prev) begin
      if (s_edges > 0 && (cyc - last_edge_cyc) != int'(cfg_div) + 1) hp_err++;
      last_edge_cyc = cyc;
      s_edges++;
      lead = (sclk != cfg_cpol);
      if (cfg_cpha ? !lead : lead) s_rx = {s_rx[14:0], mosi};
      else if (s_ptr >= 0) begin miso = s_tx[s_ptr]; s_ptr--; end
    end
    if (cs_n && !cs_prev) begin cs_rise_cyc = cyc; cs_rises++; end
    if (rx_valid) begin
      snap_rx = s_rx; snap_edges = s_edges; snap_last = last_edge_cyc;
      if (!cs_n) slave_init(slv_b);
    end
    cs_prev = cs_n; sclk_prev = sclk;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lmask(input int n);
    return (1 << n) - 1;
  endfunction

  task automatic send(input logic [15:0] w);
    tx_data = w; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    @(negedge clk);
    while (!rx_valid && n < 5000) begin @(negedge clk); n++; end
    #1;
    chk("R10 done pulse seen", int'(rx_valid), 1);
  endtask

  task automatic setup(input logic pol, input logic pha, input int div, input int len,
                       input int xd, input logic hold, input logic five);
    cfg_cpol = pol; cfg_cpha = pha; cfg_div = 8'(div); cfg_len = 5'(len);
    cfg_xdly = 5'(xd); cfg_hold = hold; cfg_five_pin = five;
    hp_err = 0;
    repeat (3) @(negedge clk);
  endtask

  // checks made at a completed, released word
  task automatic check_word(input string tag, input logic [15:0] txw, input logic [15:0] sw);
    int n, texp;
    n = int'(cfg_len);
    texp = cfg_cpha ? 1 + int'(cfg_xdly) : int'(cfg_div) + 2 + int'(cfg_xdly);
    chk({tag, " R4 rx_data"}, int'(rx_data), int'(sw) & lmask(n));
    chk({tag, " R3 mosi word"}, int'(snap_rx), int'(txw) & lmask(n));
    chk({tag, " R2 edge count"}, snap_edges, 2 * n);
    chk({tag, " R2 half period"}, hp_err, 0);
    if (cfg_cpha) chk({tag, " R6 release delay"}, cs_rise_cyc - snap_last, texp);
    else          chk({tag, " R5 release delay"}, cs_rise_cyc - snap_last, texp);
    chk({tag, " R10 cs released"}, int'(cs_n), 1);
    chk({tag, " R10 busy low"}, int'(busy), 0);
    @(negedge clk);
    chk({tag, " R10 one-cycle pulse"}, int'(rx_valid), 0);
    chk({tag, " R2 idle level"}, int'(sclk), int'(cfg_cpol));
  endtask

  task automatic t_word(input string tag, input logic pol, input logic pha, input int div,
                        input int len, input int xd, input logic [15:0] txw,
                        input logic [15:0] sw);
    setup(pol, pha, div, len, xd, 1'b0, 1'b0);
    slv_a = sw;
    send(txw);
    wait_done();
    check_word(tag, txw, sw);
  endtask

  task automatic t_ready_busy();
    setup(1'b0, 1'b0, 3, 8, 0, 1'b0, 1'b0);
    slv_a = 16'h005A;
    send(16'h00C3);
    repeat (5) @(negedge clk);
    chk("R11 ready low mid-word", int'(tx_ready), 0);
    chk("R11 busy mid-word", int'(busy), 1);
    tx_data = 16'h00FF; tx_valid = 1'b1;   // must not be taken
    wait_done();
    tx_valid = 1'b0;
    check_word("R11 ignored offer", 16'h00C3, 16'h005A);
  endtask

  task automatic t_hold();
    int rises0;
    setup(1'b0, 1'b1, 1, 8, 2, 1'b1, 1'b0);
    slv_a = 16'h0081; slv_b = 16'h007E;
    rises0 = cs_rises;
    send(16'h00A5);
    tx_data = 16'h003C; tx_valid = 1'b1;
    wait_done();
    tx_valid = 1'b0;
    chk("R7 cs held at first done", int'(cs_n), 0);
    chk("R7 busy held", int'(busy), 1);
    chk("R7 first rx", int'(rx_data), 16'h0081);
    chk("R7 first mosi", int'(snap_rx), 16'h00A5);
    hp_err = 0;
    wait_done();
    chk("R7 single release", cs_rises - rises0, 1);
    check_word("R7 second", 16'h003C, 16'h007E);
  endtask

  task automatic t_five_pin();
    setup(1'b1, 1'b0, 2, 12, 1, 1'b0, 1'b1);
    ena_n = 1'b1;
    slv_a = 16'h0ABC;
    send(16'h0531);
    repeat (40) @(negedge clk);
    #1;
    chk("R8 cs low while stalled", int'(cs_n), 0);
    chk("R8 no edges while stalled", s_edges, 0);
    chk("R8 busy while stalled", int'(busy), 1);
    ena_n = 1'b0;
    wait_done();
    check_word("R8 after grant", 16'h0531, 16'h0ABC);
    ena_n = 1'b1;
  endtask

  task automatic t_four_pin();
    ena_n = 1'b1;
    setup(1'b0, 1'b1, 0, 6, 0, 1'b0, 1'b0);
    slv_a = 16'h0015;
    send(16'h002B);
    wait_done();
    check_word("R9 enable ignored", 16'h002B, 16'h0015);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cs_n reset", int'(cs_n), 1);
    chk("R1 busy reset", int'(busy), 0);
    chk("R1 rx_valid reset", int'(rx_valid), 0);
    chk("R1 tx_ready reset", int'(tx_ready), 1);
    chk("R1 sclk idle", int'(sclk), 0);

    t_word("mode00", 1'b0, 1'b0, 1, 8, 0, 16'h00B6, 16'h0049);
    t_word("mode01", 1'b0, 1'b1, 0, 16, 0, 16'hBEEF, 16'h1357);
    t_word("mode10", 1'b1, 1'b0, 2, 2, 3, 16'hFFF2, 16'h0001);
    t_word("mode11", 1'b1, 1'b1, 3, 5, 31, 16'h0016, 16'h0019);
    t_ready_busy();
    t_hold();
    t_five_pin();
    t_four_pin();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule